// File: doc/BRIEF.md
# Manchester Packet Serial Transmitter

This block turns a short message held in a local word buffer into a Manchester-coded serial stream. Software first writes the payload words into a 32-entry buffer through a simple write port. It then presents a label word, a payload word count and the option settings, and pulses a start strobe. The block sends the label, a length word and the payload words, then a CRC-16 it computes itself, and then an optional trailing postamble word. Every word is 16 bits and goes out most significant bit first.

The half-bit period comes from an internal divider of the system clock. The divider has two settings, a fast one and a slow one; at an 80 MHz system clock the defaults give 5 Mbit/s and 400 kbit/s. When no message is being sent, the line either goes high impedance (output enable low) or repeats a programmable 16-bit idle pattern. A one-cycle pulse marks the end of each message, and a busy flag covers the time in between.

Top module: `manch_pkt_tx`

## Requirements
- R1: After reset txOe, txOut, busy and doneIrq are all 0, and the transmitter stays disabled until txEnable is set.
- R2: Each bit is sent as two half-bits of equal length. A 1 is sent high then low and a 0 is sent low then high. The first half-bit of the label appears on txOut in the cycle after the clock edge that accepts start.
- R3: The word order is label, then the length word (the payload count in the low 6 bits, upper bits zero), then payload words from buffer address 0 to count-1, then the CRC. Every word is sent MSB first.
- R4: The CRC word is CRC-16 with polynomial 0x1021 and start value 0xFFFF. It is taken over the label, the length word and the payload words, each word fed in MSB first.
- R5: When postEn is 1 at start, postPattern is sent as one extra word after the CRC. When postEn is 0, the message ends at the CRC.
- R6: rateSel (captured at start) selects the half-bit length: 0 gives FAST_DIV clock cycles and 1 gives SLOW_DIV clock cycles.
- R7: With idleMode 0, txOe is 0 and txOut is 0 whenever no message is being sent.
- R8: With txEnable 1 and idleMode 1, txOe is 1 between messages and txOut shows idlePattern one bit per half-bit period, from bit 15 down to bit 0, then repeating. The pattern restarts at bit 15 in the cycle after the edge that ends a message.
- R9: doneIrq is high for exactly one cycle. That cycle follows the edge that ends the final half-bit of the message.
- R10: A start is ignored in three cases: while busy, while txEnable is 0, or when msgLen is 0 or larger than 32. An ignored start leaves the message in flight unchanged and produces no extra doneIrq.
- R11: busy and txOe are high from the cycle after an accepted start until the cycle in which doneIrq rises. busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmitter enable |
| rateSel | input | 1 | 0 selects the fast half-bit period, 1 the slow one |
| idleMode | input | 1 | 0: tristate between messages, 1: idle pattern |
| postEn | input | 1 | Append postamble word after CRC |
| idlePattern | input | 16 | Pattern repeated between messages |
| postPattern | input | 16 | Postamble word |
| msgLabel | input | 16 | Label word sent first |
| msgLen | input | 6 | Payload word count, 1 to 32 |
| wrEn | input | 1 | Buffer write strobe |
| wrAddr | input | 5 | Buffer write address |
| wrData | input | 16 | Buffer write data |
| start | input | 1 | Start strobe |
| txOut | output | 1 | Serial line data |
| txOe | output | 1 | Line output enable |
| busy | output | 1 | Message in progress |
| doneIrq | output | 1 | One-cycle end-of-message pulse |

## Verification
The hardest case to reach from the ports is a start strobe that arrives while a message is in flight. Such a strobe must change nothing, so it can only be seen by the absence of any effect. The bench reaches it by forking a process that raises start partway through a message while the scoreboard monitor checks every half-bit of that message. It then counts doneIrq pulses, so a restarted or shortened frame shows up as a stream mismatch or as an extra pulse. A message with the full 32-word payload covers the far end of the word counter, and slow-rate and postamble runs cover the other branches of the word sequencer.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  localparam int WORD_W = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    WK_LABEL,
    WK_LEN,
    WK_DATA,
    WK_CRC,
    WK_POST
  } wordKindE;

  typedef struct packed {
    logic     load;        // load a new word, emit its first half-bit
    wordKindE kind;        // which word to load
    logic     shift;       // advance to next bit, emit its first half
    logic     secondHalf;  // emit the inverted second half-bit
    logic     sendOn;      // message active after this edge
    logic     idleOn;      // idle pattern drives the line after this edge
    logic     idleRst;     // restart idle pattern at bit 15
    logic     idleStep;    // advance idle pattern one bit
  } ctrlStrbS;

  function automatic logic [15:0] crcWord(input logic [15:0] crcIn,
                                          input logic [15:0] word);
    logic [15:0] c;
    logic        fb;
    c = crcIn;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[15] ^ word[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
  import mtx_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 100
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         txEnable,
  input  logic                         rateSel,
  input  logic                         idleMode,
  input  logic                         postEn,
  input  logic [$clog2(DEPTH):0]       msgLen,
  input  logic                         start,
  output ctrlStrbS                     strb,
  output logic [$clog2(DEPTH)-1:0]     dataAddr,
  output logic [$clog2(DEPTH):0]       msgCount,
  output logic                         busy,
  output logic                         doneIrq
);

  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int LEN_W   = ADDR_W + 1;
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);
  localparam int IDX_W   = $clog2(DEPTH + 4) + 1;
  localparam int BIT_W   = $clog2(WORD_W);

  logic              sending;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  curDiv;
  logic              tick;
  logic              rateLat;
  logic [LEN_W-1:0]  lenLat;
  logic              postLat;
  logic [IDX_W-1:0]  wordIdx;
  logic [IDX_W-1:0]  nextIdx;
  logic [IDX_W-1:0]  addrIdx;
  logic [IDX_W-1:0]  nWords;
  logic [BIT_W-1:0]  bitIdx;
  logic              half;
  logic              lenOk;
  logic              accept;
  logic              lastBit;
  logic              lastWord;
  logic              finish;
  wordKindE          nextKind;

  // Half-bit divider: rate captured at start while sending, live otherwise
  always_comb begin
    if (sending) curDiv = rateLat ? DIV_W'(SLOW_DIV) : DIV_W'(FAST_DIV);
    else         curDiv = rateSel ? DIV_W'(SLOW_DIV) : DIV_W'(FAST_DIV);
  end
  assign tick = (divCnt >= curDiv - 1'b1);

  assign lenOk    = (msgLen != '0) && (msgLen <= LEN_W'(DEPTH));
  assign accept   = start && !sending && txEnable && lenOk;
  assign nWords   = IDX_W'(3) + IDX_W'(lenLat) + IDX_W'(postLat);
  assign lastWord = (wordIdx == nWords - 1'b1);
  assign lastBit  = (bitIdx == BIT_W'(WORD_W - 1));
  assign finish   = sending && tick && half && lastBit && lastWord;

  assign nextIdx  = wordIdx + 1'b1;
  assign addrIdx  = wordIdx - 1'b1;
  assign dataAddr = addrIdx[ADDR_W-1:0];
  assign msgCount = lenLat;

  always_comb begin
    if (nextIdx == IDX_W'(1))                       nextKind = WK_LEN;
    else if (nextIdx <= IDX_W'(lenLat) + IDX_W'(1)) nextKind = WK_DATA;
    else if (nextIdx == IDX_W'(lenLat) + IDX_W'(2)) nextKind = WK_CRC;
    else                                            nextKind = WK_POST;
  end

  always_comb begin
    strb.load       = accept || (sending && tick && half && lastBit && !lastWord);
    strb.kind       = accept ? WK_LABEL : nextKind;
    strb.shift      = sending && tick && half && !lastBit;
    strb.secondHalf = sending && tick && !half;
    strb.sendOn     = accept || (sending && !finish);
    strb.idleOn     = !strb.sendOn && txEnable && idleMode;
    strb.idleRst    = accept || finish || !strb.idleOn;
    strb.idleStep   = strb.idleOn && !sending && tick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sending <= 1'b0;
      divCnt  <= '0;
      rateLat <= 1'b0;
      lenLat  <= '0;
      postLat <= 1'b0;
      wordIdx <= '0;
      bitIdx  <= '0;
      half    <= 1'b0;
      doneIrq <= 1'b0;
    end else begin
      divCnt  <= (accept || tick) ? '0 : divCnt + 1'b1;
      sending <= strb.sendOn;
      doneIrq <= finish;
      if (accept) begin
        rateLat <= rateSel;
        lenLat  <= msgLen;
        postLat <= postEn;
        wordIdx <= '0;
        bitIdx  <= '0;
        half    <= 1'b0;
      end else if (sending && tick) begin
        if (!half) begin
          half <= 1'b1;
        end else begin
          half <= 1'b0;
          if (lastBit) begin
            bitIdx  <= '0;
            wordIdx <= nextIdx;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end
    end
  end

  assign busy = sending;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !busy);

  // R10
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sending && start && !tick) |=> (sending && $stable(wordIdx) && $stable(lenLat)));

endmodule

// File: rtl/mtx_dpath.sv
module mtx_dpath
  import mtx_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrbS                   strb,
  input  logic [$clog2(DEPTH)-1:0]   dataAddr,
  input  logic [$clog2(DEPTH):0]     msgCount,
  input  logic [WORD_W-1:0]          msgLabel,
  input  logic [WORD_W-1:0]          postPattern,
  input  logic [WORD_W-1:0]          idlePattern,
  input  logic                       wrEn,
  input  logic [$clog2(DEPTH)-1:0]   wrAddr,
  input  logic [WORD_W-1:0]          wrData,
  output logic                       txOut,
  output logic                       txOe
);

  localparam int BIT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] wordBuf [DEPTH];
  logic [WORD_W-1:0] selWord;
  logic [WORD_W-1:0] shReg;
  logic [15:0]       crcReg;
  logic [BIT_W-1:0]  idleIdx;
  logic [BIT_W-1:0]  idleNext;
  logic              outReg;
  logic              oeReg;

  // Payload buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) wordBuf[i] <= '0;
    end else if (wrEn) begin
      wordBuf[wrAddr] <= wrData;
    end
  end

  always_comb begin
    unique case (strb.kind)
      WK_LABEL: selWord = msgLabel;
      WK_LEN:   selWord = WORD_W'(msgCount);
      WK_DATA:  selWord = wordBuf[dataAddr];
      WK_CRC:   selWord = crcReg;
      default:  selWord = postPattern;
    endcase
  end

  // CRC folds a whole word in when it is loaded
  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= '0;
    end else if (strb.load) begin
      if (strb.kind == WK_LABEL)
        crcReg <= crcWord(CRC_SEED, selWord);
      else if (strb.kind == WK_LEN || strb.kind == WK_DATA)
        crcReg <= crcWord(crcReg, selWord);
    end
  end

  assign idleNext = idleIdx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      outReg  <= 1'b0;
      oeReg   <= 1'b0;
      idleIdx <= '0;
    end else begin
      oeReg <= strb.sendOn || strb.idleOn;

      if (strb.idleRst)       idleIdx <= '0;
      else if (strb.idleStep) idleIdx <= idleNext;

      if (strb.load) begin
        shReg  <= selWord;
        outReg <= selWord[WORD_W-1];
      end else if (strb.shift) begin
        shReg  <= {shReg[WORD_W-2:0], 1'b0};
        outReg <= shReg[WORD_W-2];
      end else if (strb.secondHalf) begin
        outReg <= ~shReg[WORD_W-1];
      end else if (!strb.sendOn) begin
        if (strb.idleRst)       outReg <= strb.idleOn ? idlePattern[WORD_W-1] : 1'b0;
        else if (strb.idleStep) outReg <= idlePattern[BIT_W'(WORD_W-1) - idleNext];
      end
    end
  end

  assign txOut = outReg;
  assign txOe  = oeReg;

  // R2
  manch_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.secondHalf |=> (txOut != $past(txOut)));

  // R8
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.idleOn && strb.idleRst) |=> (txOut == $past(idlePattern[WORD_W-1])));

endmodule

// File: rtl/manch_pkt_tx.sv
module manch_pkt_tx
  import mtx_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 100
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       txEnable,
  input  logic                       rateSel,
  input  logic                       idleMode,
  input  logic                       postEn,
  input  logic [15:0]                idlePattern,
  input  logic [15:0]                postPattern,
  input  logic [15:0]                msgLabel,
  input  logic [$clog2(DEPTH):0]     msgLen,
  input  logic                       wrEn,
  input  logic [$clog2(DEPTH)-1:0]   wrAddr,
  input  logic [15:0]                wrData,
  input  logic                       start,
  output logic                       txOut,
  output logic                       txOe,
  output logic                       busy,
  output logic                       doneIrq
);

  localparam int ADDR_W = $clog2(DEPTH);

  ctrlStrbS            strb;
  logic [ADDR_W-1:0]   dataAddr;
  logic [ADDR_W:0]     msgCount;

  mtx_ctrl #(
    .DEPTH(DEPTH), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .rateSel(rateSel),
    .idleMode(idleMode), .postEn(postEn), .msgLen(msgLen), .start(start),
    .strb(strb), .dataAddr(dataAddr), .msgCount(msgCount),
    .busy(busy), .doneIrq(doneIrq)
  );

  mtx_dpath #(
    .DEPTH(DEPTH)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .dataAddr(dataAddr),
    .msgCount(msgCount), .msgLabel(msgLabel), .postPattern(postPattern),
    .idlePattern(idlePattern), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txOut(txOut), .txOe(txOe)
  );

  // R7
  tristate_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start && !idleMode) |=> !txOe);

  // R11
  busy_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> txOe);

endmodule

// File: tb/manch_pkt_tx_tb_top.sv
module manch_pkt_tx_tb_top;

  localparam int DEPTH = 32;
  localparam int FD    = 4;
  localparam int SD    = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txEnable = 1'b0, rateSel = 1'b0, idleMode = 1'b0, postEn = 1'b0;
  logic [15:0] idlePattern = '0, postPattern = '0, msgLabel = '0;
  logic [5:0]  msgLen = '0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        start = 1'b0;
  logic        txOut, txOe, busy, doneIrq;

  always #2.5 clk = ~clk;

  manch_pkt_tx #(.DEPTH(DEPTH), .FAST_DIV(FD), .SLOW_DIV(SD)) dut_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .rateSel(rateSel),
    .idleMode(idleMode), .postEn(postEn), .idlePattern(idlePattern),
    .postPattern(postPattern), .msgLabel(msgLabel), .msgLen(msgLen),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .start(start),
    .txOut(txOut), .txOe(txOe), .busy(busy), .doneIrq(doneIrq)
  );

  int          nChecks = 0;
  int          nFails  = 0;
  int          curDiv  = FD;
  int          doneCnt = 0;
  bit          monDone = 1'b0;
  bit          expQ[$];
  logic [15:0] shadow [DEPTH];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [15:0] w);
    logic fb;
    for (int b = 15; b >= 0; b--) begin
      fb = c[15] ^ w[b];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  always @(posedge clk) if (doneIrq) doneCnt++;

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R9 watchdog: actual 0 expected 1 (message never completed)");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  // Monitor: pops expected half-bits as the line produces them
  initial begin
    bit e;
    forever begin
      @(posedge busy);
      @(negedge clk);
      while (expQ.size() > 0) begin
        e = expQ.pop_front();
        chk(txOut == e, "R2/R3/R4 half-bit", txOut, e);
        chk(txOe && busy && !doneIrq, "R11 active line", {txOe, busy, doneIrq}, 3'b110);
        if (expQ.size() > 0) repeat (curDiv) @(negedge clk);
      end
      repeat (curDiv) @(negedge clk);
      chk(doneIrq == 1'b1, "R9 done pulse", doneIrq, 1);
      chk(busy == 1'b0, "R11 busy drop", busy, 0);
      if (idleMode) begin
        chk(txOe == 1'b1, "R8 idle oe", txOe, 1);
        chk(txOut == idlePattern[15], "R8 idle restart", txOut, idlePattern[15]);
      end else begin
        chk({txOe, txOut} == 2'b00, "R7 tristate", {txOe, txOut}, 0);
      end
      monDone = 1'b1;
    end
  end

  task automatic writeBuf(input int a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = d;
    shadow[a] = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sendMsg(input logic [15:0] lab, input int len, input bit rate,
                         input bit post, input logic [15:0] pp,
                         input bit midStart, input bit idleChk);
    logic [15:0] ws[$];
    logic [15:0] crc;
    int          d0;
    ws.push_back(lab);
    ws.push_back(16'(len));
    for (int i = 0; i < len; i++) ws.push_back(shadow[i]);
    crc = 16'hFFFF;
    foreach (ws[i]) crc = refCrc(crc, ws[i]);
    ws.push_back(crc);
    if (post) ws.push_back(pp);
    foreach (ws[i])
      for (int b = 15; b >= 0; b--) begin
        expQ.push_back(ws[i][b]);
        expQ.push_back(~ws[i][b]);
      end
    curDiv  = rate ? SD : FD;
    monDone = 1'b0;
    d0      = doneCnt;
    @(negedge clk);
    msgLabel = lab; msgLen = 6'(len); rateSel = rate; postEn = post;
    postPattern = pp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      fork
        begin
          repeat (50) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      join_none
    end
    wait (monDone);
    if (idleChk) begin
      for (int j = 1; j <= 17; j++) begin
        for (int k = 0; k < FD; k++) begin
          @(negedge clk);
          if (j == 1 && k == 0) chk(doneIrq == 1'b0, "R9 single cycle", doneIrq, 0);
        end
        chk(txOut == idlePattern[4'(15 - j)], "R8 idle bit", txOut, idlePattern[4'(15 - j)]);
      end
    end else begin
      @(negedge clk);
      chk(doneIrq == 1'b0, "R9 single cycle", doneIrq, 0);
    end
    repeat (10) @(negedge clk);
    chk(doneCnt - d0 == 1, "R10 one done per message", doneCnt - d0, 1);
    chk(busy == 1'b0, "R10 no restart", busy, 0);
  endtask

  task automatic tryStart(input int len, input string tag);
    @(negedge clk);
    msgLen = 6'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, tag, busy, 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && doneIrq == 1'b0, tag, busy, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({txOe, txOut, busy, doneIrq} == 4'b0, "R1 in reset", {txOe, txOut, busy, doneIrq}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk({txOe, txOut, busy, doneIrq} == 4'b0, "R1 after reset", {txOe, txOut, busy, doneIrq}, 0);

    // R10 disabled start ignored
    tryStart(3, "R10 start while disabled");

    txEnable = 1'b1;
    // R10 bad lengths ignored
    tryStart(0, "R10 zero length");
    tryStart(33, "R10 oversize length");

    // R2 R3 R4 R7 fast rate, tristate idle
    writeBuf(0, 16'hA5C3);
    writeBuf(1, 16'h0001);
    writeBuf(2, 16'hFFFF);
    sendMsg(16'h8001, 3, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    chk(txOe == 1'b0, "R7 tristate after", txOe, 0);

    // R5 R6 slow rate with postamble
    writeBuf(0, 16'h1234);
    sendMsg(16'h00FF, 1, 1'b1, 1'b1, 16'h7E7E, 1'b0, 1'b0);

    // R8 full payload, idle pattern between messages
    for (int i = 0; i < DEPTH; i++) writeBuf(i, 16'(i * 16'h0101) ^ 16'h5A00);
    @(negedge clk);
    idlePattern = 16'hC35A; idleMode = 1'b1;
    repeat (2) @(negedge clk);
    chk(txOe == 1'b1, "R8 idle oe before message", txOe, 1);
    sendMsg(16'hBEEF, 32, 1'b0, 1'b1, 16'h0F0F, 1'b0, 1'b1);

    // R10 start during a message
    @(negedge clk);
    idleMode = 1'b0;
    sendMsg(16'h4242, 2, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule